// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Controller with Programmable Bursts

This block moves a run of data items between one peripheral and memory without ever holding the data itself. When the peripheral raises its request and items remain to be moved, the controller asks the processor to stop using the bus. Once the processor grants the bus, the controller drives the memory address and a read or write strobe, and it raises an acknowledge to the peripheral at the same time. The peripheral then drives the data bus (memory write) or captures it (memory read) in that same cycle. Every item therefore costs exactly one memory cycle.

Software sets a start address, an item count and a control word while the controller is idle. The control word selects the direction and one of three grant policies. Single mode moves one item per grant. Block mode moves the whole remaining count in one grant. Burst mode moves a programmed number of items and then hands the bus back, so processor and DMA cycles interleave. When the count is used up, a terminal-count flag goes high and the controller stops requesting the bus until a new count is written.

Top module: `flyby_dma`

## Requirements
- R1: From idle, with the bus handed back (hold_ack low), DREQ high and the count nonzero, hold_req rises in the cycle after DREQ is sampled. No address or strobe is driven until hold_ack has been seen high, and whenever mem_addr_oe is high both hold_req and hold_ack are high.
- R2: Every transfer is one setup cycle (mem_addr_oe high, address valid, no strobe), then one strobe cycle with the same address and DACK high. The strobe is low in the cycle that follows.
- R3: Control bit 0 selects the direction. 0 means peripheral-to-memory and uses mem_wr. 1 means memory-to-peripheral and uses mem_rd. The two strobes are never high together, and DACK is high exactly in strobe cycles.
- R4: The address advances by one after each transfer, wrapping modulo 2^ADDR_W, and the count drops by one. The bench sees this as consecutive strobe addresses.
- R5: When the last item has moved, tc goes high and hold_req drops. With tc high, or with a count of zero, no bus request is made even while DREQ stays high. Writing the count register clears tc.
- R6: Mode field (control bits 2:1) = 00 (and the unused code 11) is single mode: each grant carries exactly one transfer.
- R7: Mode field 01 is block mode: while DREQ stays high, the whole count moves in one grant with back-to-back transfers.
- R8: Mode field 10 is burst mode: control bits 6:3 hold N, and each grant carries N+1 transfers, or fewer if fewer remain. The bus is requested again only while DREQ is high and the count is nonzero.
- R9: If DREQ is low at the end of a strobe cycle, that transfer completes and hold is released. The rest of the count moves in later grants.
- R10: Register writes (reg_sel 0 = address, 1 = count, 2 = control) take effect only while idle. While a bus request is pending or the bus is owned, they are ignored.
- R11: After reset, all outputs are low, mem_addr is zero, the count is zero and tc is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| reg_wdata | input | ADDR_W | Register write data |
| hold_req | output | 1 | Request that the processor hold off the bus |
| hold_ack | input | 1 | Processor has released the bus |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Acknowledge to peripheral, high in strobe cycles |
| mem_addr | output | ADDR_W | Memory address, zero when not driven |
| mem_addr_oe | output | 1 | Address bus driven by the controller |
| mem_rd | output | 1 | Memory read strobe (memory to peripheral) |
| mem_wr | output | 1 | Memory write strobe (peripheral to memory) |
| tc | output | 1 | Terminal count reached |

## Verification
The bench sweeps both directions, all three grant policies, several counts and several burst lengths, and compares each grant's transfer count with the split it computes itself. Wrong burst counting shows up as a grant that is one transfer too long or too short. A case that starts near the top of the address space checks the wrap; a design that got it wrong would show a jump in the strobe addresses. A DREQ drop in mid-block must cut the grant right after the current transfer and leave the remainder for a later grant. Register writes made while the bus is owned must leave the address sequence and the total count untouched. The bench also confirms that no request appears with a zero count or after the terminal count, and that a count write clears tc.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    localparam int BURST_W = 4;
    localparam int CTRL_W  = 3 + BURST_W;

    localparam logic [1:0] MODE_SINGLE = 2'b00;
    localparam logic [1:0] MODE_BLOCK  = 2'b01;
    localparam logic [1:0] MODE_BURST  = 2'b10;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_SETUP,
        ST_STROBE
    } seq_state_t;

    typedef struct packed {
        logic [BURST_W-1:0] burst_m1;
        logic [1:0]         mode;
        logic               to_periph;
    } dma_ctrl_t;

    function automatic logic grant_ends(
        input logic [1:0]         mode,
        input logic [BURST_W-1:0] burst_m1,
        input logic [BURST_W-1:0] beats_done,
        input logic               last_item,
        input logic               dreq
    );
        logic stop;
        stop = last_item || !dreq;
        case (mode)
            MODE_BLOCK: ;
            MODE_BURST: stop = stop || (beats_done == burst_m1);
            default:    stop = 1'b1;
        endcase
        return stop;
    endfunction

endpackage

// File: rtl/flyby_dma_regs.sv
module flyby_dma_regs
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output dma_ctrl_t         ctrl,
    output logic              tc
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            ctrl     <= '0;
            tc       <= 1'b0;
        end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
            cur_cnt  <= cur_cnt - 1'b1;
            tc       <= (cur_cnt == CNT_ONE);
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ADDR: cur_addr <= wr_data;
                SEL_CNT: begin
                    cur_cnt <= wr_data[CNT_W-1:0];
                    tc      <= 1'b0;
                end
                SEL_CTRL: ctrl <= dma_ctrl_t'(wr_data[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (cur_addr == $past(cur_addr) + 1'b1)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (cur_cnt == $past(cur_cnt) - 1'b1)); // R4

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !step) |=> ($stable(cur_addr) && $stable(cur_cnt) && $stable(ctrl))); // R10

endmodule

// File: rtl/flyby_dma_beats.sv
module flyby_dma_beats
    import flyby_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               inc,
    output logic [BURST_W-1:0] beats
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            beats <= '0;
        end else if (inc) begin
            beats <= beats + 1'b1;
        end
    end

    AST_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> (beats == '0)); // R8

endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
    import flyby_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               dreq,
    input  logic               hold_ack,
    input  logic               cnt_nonzero,
    input  logic               last_item,
    input  logic [1:0]         mode,
    input  logic [BURST_W-1:0] burst_m1,
    input  logic [BURST_W-1:0] beats,
    output seq_state_t         state,
    output logic               step,
    output logic               grant_start
);

    seq_state_t state_nx;
    logic       stop_now;

    assign stop_now    = grant_ends(mode, burst_m1, beats, last_item, dreq);
    assign step        = (state == ST_STROBE);
    assign grant_start = (state == ST_REQ) && hold_ack;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (dreq && cnt_nonzero && !hold_ack) state_nx = ST_REQ;
            ST_REQ:    if (hold_ack) state_nx = ST_SETUP;
            ST_SETUP:  state_nx = ST_STROBE;
            ST_STROBE: state_nx = stop_now ? ST_IDLE : ST_SETUP;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    AST_REQ_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REQ && !hold_ack) |=> (state == ST_REQ)); // R1

    AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (rst)
        (step && (mode == MODE_SINGLE)) |=> (state == ST_IDLE)); // R6

    AST_DREQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (step && !dreq) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic              hold_req,
    input  logic              hold_ack,
    input  logic              dreq,
    output logic              dack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_addr_oe,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              tc
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    seq_state_t         state;
    logic               step;
    logic               grant_start;
    logic [ADDR_W-1:0]  cur_addr;
    logic [CNT_W-1:0]   cur_cnt;
    dma_ctrl_t          ctrl;
    logic [BURST_W-1:0] beats;
    logic               wr_ok;
    logic               strobing;

    assign wr_ok = reg_we && (state == ST_IDLE);

    flyby_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ok),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata),
        .step     (step),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .ctrl     (ctrl),
        .tc       (tc)
    );

    flyby_dma_beats u_beats (
        .clk   (clk),
        .rst   (rst),
        .clear (grant_start),
        .inc   (step),
        .beats (beats)
    );

    flyby_dma_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .dreq        (dreq),
        .hold_ack    (hold_ack),
        .cnt_nonzero (cur_cnt != '0),
        .last_item   (cur_cnt == CNT_ONE),
        .mode        (ctrl.mode),
        .burst_m1    (ctrl.burst_m1),
        .beats       (beats),
        .state       (state),
        .step        (step),
        .grant_start (grant_start)
    );

    assign strobing    = (state == ST_STROBE);
    assign hold_req    = (state != ST_IDLE);
    assign mem_addr_oe = (state == ST_SETUP) || strobing;
    assign mem_addr    = mem_addr_oe ? cur_addr : '0;
    assign mem_rd      = strobing && ctrl.to_periph;
    assign mem_wr      = strobing && !ctrl.to_periph;
    assign dack        = strobing;

    AST_BUS_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_addr_oe |-> (hold_req && hold_ack)); // R1

    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> ($past(mem_addr_oe) && !$past(mem_rd || mem_wr)
                                && (mem_addr == $past(mem_addr)))); // R2

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R3

    AST_TC_QUIET: assert property (@(posedge clk) disable iff (rst)
        tc |-> !hold_req); // R5

    AST_BURST_CAP: assert property (@(posedge clk) disable iff (rst)
        (strobing && ctrl.mode == MODE_BURST) |-> (beats <= ctrl.burst_m1)); // R8

endmodule

// File: tb/flyby_dma_tb.sv
module flyby_dma_tb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic          hold_req;
    logic          hold_ack = 1'b0;
    logic          dreq = 1'b0;
    logic          dack;
    logic [AW-1:0] mem_addr;
    logic          mem_addr_oe;
    logic          mem_rd;
    logic          mem_wr;
    logic          tc;

    always #2 clk = ~clk;

    flyby_dma #(.ADDR_W(AW), .CNT_W(8)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .hold_req(hold_req), .hold_ack(hold_ack), .dreq(dreq), .dack(dack),
        .mem_addr(mem_addr), .mem_addr_oe(mem_addr_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .tc(tc)
    );

    // processor model: grants the bus one cycle after the request
    always @(posedge clk) hold_ack <= rst ? 1'b0 : hold_req;

    int nvec = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state
    logic [AW-1:0] exp_addr;
    logic          exp_rd;
    int            nstrobes;
    int            grant_sz [0:63];
    int            ngrants;
    int            cur_grant;
    logic          p_oe, p_strobe, p_hreq;
    logic [AW-1:0] p_addr;
    bit            mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_addr_oe) chk(hold_req && hold_ack, "R1 bus driven without hold", int'(hold_ack), 1);
            if (mem_rd || mem_wr) begin
                chk(mem_addr == exp_addr, "R4 strobe address", int'(mem_addr), int'(exp_addr));
                chk(mem_rd == exp_rd && mem_wr == !exp_rd, "R3 strobe direction", int'(mem_rd), int'(exp_rd));
                chk(dack, "R3 dack with strobe", int'(dack), 1);
                chk(p_oe && !p_strobe && p_addr == mem_addr, "R2 setup before strobe", int'(p_oe), 1);
                exp_addr = exp_addr + 1'b1;
                nstrobes++;
                cur_grant++;
            end else begin
                chk(!dack, "R3 dack outside strobe", int'(dack), 0);
            end
            if (hold_req && !p_hreq) cur_grant = 0;
            if (!hold_req && p_hreq) begin
                if (ngrants < 64) grant_sz[ngrants] = cur_grant;
                ngrants++;
            end
        end
        p_oe     = mem_addr_oe;
        p_strobe = mem_rd || mem_wr;
        p_addr   = mem_addr;
        p_hreq   = hold_req;
    end

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clear_stats(input logic [AW-1:0] a, input logic rd);
        exp_addr = a; exp_rd = rd; nstrobes = 0; ngrants = 0; cur_grant = 0;
    endtask

    task automatic wait_tc();
        for (int i = 0; i < 400 && !tc; i++) @(negedge clk);
    endtask

    task automatic settle();
        dreq = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_case(input logic rd, input int mode, input int cnt, input int m1,
                            input logic [AW-1:0] base);
        int exp_g [0:63];
        int neg, rem, g;
        string rq;
        rq = (mode == 1) ? "R7" : (mode == 2) ? "R8" : "R6";
        wr(2'd0, base);
        wr(2'd1, AW'(cnt));
        wr(2'd2, AW'((m1 << 3) | (mode << 1) | int'(rd)));
        clear_stats(base, rd);
        neg = 0; rem = cnt;
        while (rem > 0) begin
            g = (mode == 1) ? rem : (mode == 2) ? ((m1 + 1 < rem) ? m1 + 1 : rem) : 1;
            exp_g[neg] = g; neg++; rem -= g;
        end
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk);
        chk(hold_req && !mem_addr_oe, "R1 request timing", int'(hold_req), 1);
        wait_tc();
        repeat (6) @(negedge clk);
        chk(tc, "R5 terminal count", int'(tc), 1);
        chk(!hold_req, "R5 quiet after tc", int'(hold_req), 0);
        chk(nstrobes == cnt, "R4 total transfers", nstrobes, cnt);
        chk(ngrants == neg, {rq, " grant count"}, ngrants, neg);
        for (int k = 0; k < neg && k < ngrants && k < 64; k++)
            chk(grant_sz[k] == exp_g[k], {rq, " grant size"}, grant_sz[k], exp_g[k]);
        settle();
    endtask

    initial begin
        #200000;
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!hold_req && !dack && !mem_rd && !mem_wr && !mem_addr_oe && !tc && mem_addr == '0,
            "R11 reset outputs", int'(hold_req), 0);
        mon_on = 1'b1;

        // R5 zero count never requests
        clear_stats('0, 1'b0);
        dreq = 1'b1;
        repeat (8) @(negedge clk);
        chk(!hold_req && nstrobes == 0, "R5 zero count no request", int'(hold_req), 0);
        settle();

        // sweep
        for (int d = 0; d < 2; d++)
            for (int m = 0; m < 3; m++)
                for (int c = 1; c <= 5; c += 2)
                    for (int b = 0; b < 3; b++)
                        if (m == 2 || b == 0)
                            run_case(d[0], m, c, b, AW'(16'h0100 + d * 64 + m * 16 + c));

        // unused mode code behaves as single
        run_case(1'b0, 3, 3, 0, 16'h0400);
        // address wrap
        run_case(1'b1, 1, 4, 0, 16'hFFFE);
        run_case(1'b0, 2, 5, 1, 16'hFFFD);

        // R9 dreq drop mid block
        wr(2'd0, 16'h0300);
        wr(2'd1, 16'd6);
        wr(2'd2, 16'(1 << 1));
        clear_stats(16'h0300, 1'b0);
        @(negedge clk);
        dreq = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 100 && seen < 2; i++) begin
                @(negedge clk);
                if (mem_rd || mem_wr) seen++;
            end
        end
        dreq = 1'b0;
        repeat (6) @(negedge clk);
        chk(ngrants == 1 && grant_sz[0] == 2, "R9 grant cut after dreq drop", grant_sz[0], 2);
        chk(!tc && !hold_req, "R9 released without tc", int'(hold_req), 0);
        dreq = 1'b1;
        wait_tc();
        repeat (6) @(negedge clk);
        chk(ngrants == 2 && grant_sz[1] == 4, "R9 remainder grant", grant_sz[1], 4);
        chk(nstrobes == 6, "R9 total transfers", nstrobes, 6);
        settle();

        // R10 writes ignored while bus owned
        wr(2'd0, 16'h0200);
        wr(2'd1, 16'd4);
        wr(2'd2, 16'(1 << 1) | 16'd1);
        clear_stats(16'h0200, 1'b1);
        @(negedge clk);
        dreq = 1'b1;
        for (int i = 0; i < 20 && !hold_req; i++) @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0900;
        @(negedge clk);
        reg_sel = 2'd1; reg_wdata = 16'd1;
        @(negedge clk);
        reg_sel = 2'd2; reg_wdata = 16'd0;
        @(negedge clk);
        reg_we = 1'b0;
        wait_tc();
        repeat (6) @(negedge clk);
        chk(nstrobes == 4, "R10 count write ignored", nstrobes, 4);
        chk(ngrants == 1, "R10 control write ignored", ngrants, 1);
        chk(exp_addr == 16'h0204, "R10 address write ignored", int'(exp_addr), 16'h0204);
        // R5 tc cleared by count write
        dreq = 1'b0;
        repeat (3) @(negedge clk);
        wr(2'd1, 16'd2);
        chk(!tc, "R5 count write clears tc", int'(tc), 0);
        settle();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule